// File: doc/BRIEF.md
# SPI Controller with Mode Fault

A byte-wide serial peripheral interface shift engine that works either as the bus master or as a selected slave. Software configures it through three 8-bit registers on a simple strobe bus: control, status and data. In master mode the block divides the system clock to make SCK. It shifts the byte written to the data register out on MOSI, most significant bit first, and at the same time collects the byte arriving on MISO. In slave mode the same shifter is clocked by the external SCK while the external slave select is low, and the data register supplies the byte returned on MISO.

Every pad is split into a value and an output enable so that the surrounding pad ring can override direction. The slave select input frames slave transfers. Raising it resets the slave's shifter and bit counter at once, so a partly received byte is dropped and the next frame starts aligned. In master mode the select pad can serve as an ordinary output, or as an input that watches for a competing master. If that input goes low, the block clears its own master bit, gives up SCK and MOSI, aborts the transfer and raises the completion flag. It stays a slave until software sets the master bit again.

The bus uses SPI mode 0. SCK idles low, both sides sample on the rising (leading) edge and both sides shift on the falling (trailing) edge.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset the control and status registers read 0x00, sck_o is 0, and all four output enables are 0.
- R2: Control register (reg_sel=0) holds the following bits. Bit 0 is enable and bit 1 is master. Bit 2 makes SS an output in master mode. Bit 3 allows MISO drive in slave mode. Bits 6:4 are the divider select and bit 7 is the SS output level. A write reads back unchanged unless a mode fault clears bit 1.
- R3: With enable and master set and no transfer running, a write to the data register (reg_sel=2) starts a transfer of 8 SCK pulses, with SCK idling low. The byte goes out on mosi_o MSB first and changes on falling SCK. miso_i is sampled on rising SCK. Reading reg_sel=2 afterwards returns the received byte.
- R4: The master SCK period is 2^(sel+1) system clocks, where sel is control bits 6:4. Each half period lasts 2^sel clocks.
- R5: Status register (reg_sel=1) bit 7 is the flag and bit 0 is busy. The flag sets when the eighth bit of a byte is sampled in either mode, or on a mode fault. Busy is 1 while a master transfer runs.
- R6: The flag clears only on a data register read or write that follows a status read which returned the flag set. A data access with no such status read leaves the flag set.
- R7: As an enabled slave (bit 1 clear) with ss_i low, the block samples mosi_i on rising sck_i. It presents the data register byte on miso_o MSB first, changing on falling sck_i. After eight bits the received byte is readable at reg_sel=2.
- R8: As a slave with ss_i high, SCK and MOSI activity has no effect: the flag stays clear and the received byte is unchanged.
- R9: miso_oe is 1 only for an enabled slave with ss_i low and control bit 3 set. It is never 1 together with sck_oe or mosi_oe.
- R10: A rising ss_i in slave mode discards partly shifted bits and reloads the transmit byte, so the next frame receives and sends a whole aligned byte.
- R11: In master mode with control bit 2 set, ss_i has no effect, ss_oe is 1 and ss_o follows control bit 7.
- R12: In master mode with control bit 2 clear, ss_i low is a mode fault. Control bit 1 clears, the flag sets, any transfer aborts with SCK low, and sck_oe and mosi_oe drop.
- R13: After a mode fault the block stays a slave and drives neither SCK nor MOSI until software writes control bit 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one clock later |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| sck_i | input | 1 | SCK pad input |
| sck_o | output | 1 | SCK pad value in master mode |
| sck_oe | output | 1 | SCK pad output enable |
| mosi_i | input | 1 | MOSI pad input |
| mosi_o | output | 1 | MOSI pad value |
| mosi_oe | output | 1 | MOSI pad output enable |
| miso_i | input | 1 | MISO pad input |
| miso_o | output | 1 | MISO pad value |
| miso_oe | output | 1 | MISO pad output enable |
| ss_i | input | 1 | Slave select pad input, active low |
| ss_o | output | 1 | Slave select pad value when used as an output |
| ss_oe | output | 1 | Slave select pad output enable |

## Verification
The bench uses a slave select that rises after three bits and then falls again. A design that kept the partial bits would receive a byte shifted by three places and send a misaligned reply. It also pulls SS low in the middle of a master transfer with SS as an input: a faulty design would keep toggling SCK, keep its master bit, or fail to raise the flag. The other side of that case is covered too, with SS as an output held low and the master kept running. Flag clearing is tested with a data read that has no status read before it, which must leave the flag set. SCK is also toggled while the slave is deselected, where a leaky design would receive data or raise the flag.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  // Control register layout, MSB first (R2)
  typedef struct packed {
    logic             ss_level;
    logic [DIV_W-1:0] div_sel;
    logic             miso_drv;
    logic             ss_is_out;
    logic             master;
    logic             enable;
  } ctrl_t;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mf_clkgen.sv
module spi_mf_clkgen #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             halt,
  input  logic [SEL_W-1:0] half_sel,
  output logic             sck_q,
  output logic             lead,
  output logic             trail
);
  localparam int unsigned CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             hit;

  // half period = 2^half_sel clocks (R4)
  assign limit = (CNT_W'(1) << half_sel) - CNT_W'(1);
  assign hit   = run && (cnt == limit);
  assign lead  = hit && !sck_q;
  assign trail = hit && sck_q;

  always_ff @(posedge clk) begin
    if (rst || halt || !run) begin
      cnt   <= '0;
      sck_q <= 1'b0;
    end else if (hit) begin
      cnt   <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R4: SCK only toggles at the end of a half period
  p_toggle_on_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !halt && !hit) |=> $stable(sck_q))
    else $error("sck toggled mid half period");
endmodule

// File: rtl/spi_mf_engine.sv
module spi_mf_engine #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         is_master,
  input  logic         slv_sel,
  input  logic         abort,
  input  logic         start,
  input  logic [W-1:0] start_byte,
  input  logic [W-1:0] tx_buf,
  input  logic         m_lead,
  input  logic         m_trail,
  input  logic         sck_s,
  input  logic         mosi_s,
  input  logic         miso_raw,
  output logic         busy,
  output logic         done,
  output logic         out_bit,
  output logic [W-1:0] rx_byte
);
  localparam int unsigned BIT_W = $clog2(W + 1);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(W - 1);
  localparam logic [BIT_W-1:0] FULL = BIT_W'(W);

  logic [W-1:0]     sh;
  logic             lat;
  logic [BIT_W-1:0] cnt;
  logic             sck_prev;
  logic             lead, trail, in_bit;

  always_comb begin
    if (is_master) begin
      lead   = busy && m_lead;
      trail  = busy && m_trail;
      in_bit = miso_raw;
    end else begin
      lead   = slv_sel && sck_s && !sck_prev;
      trail  = slv_sel && !sck_s && sck_prev;
      in_bit = mosi_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      lat     <= 1'b0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        // R12: mode fault kills the transfer
        busy <= 1'b0;
        cnt  <= '0;
        sh   <= tx_buf;
      end else if (!is_master && !slv_sel) begin
        // R8/R10: deselected or disabled, hold aligned and reloaded
        busy <= 1'b0;
        cnt  <= '0;
        sh   <= tx_buf;
      end else if (is_master && !busy) begin
        if (start) begin
          sh   <= start_byte;
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (lead) begin
        lat <= in_bit;
        cnt <= cnt + BIT_W'(1);
        if (cnt == LAST) begin
          rx_byte <= {sh[W-2:0], in_bit};
          done    <= 1'b1;
        end
      end else if (trail) begin
        if (cnt == FULL) begin
          cnt  <= '0;
          busy <= 1'b0;
          sh   <= is_master ? {sh[W-2:0], lat} : tx_buf;
        end else begin
          sh <= {sh[W-2:0], lat};
        end
      end
    end
  end

  assign out_bit = sh[W-1];

  p_bitcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL)
    else $error("bit counter beyond byte length");

  p_passive_no_done_r8: assert property (@(posedge clk) disable iff (rst)
    (!is_master && !slv_sel) |=> !done)
    else $error("byte completed while passive");
endmodule

// File: rtl/spi_mf_regs.sv
module spi_mf_regs
  import spi_mf_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             ss_s,
  input  logic             busy,
  input  logic             done,
  input  logic [W-1:0]     rx_byte,
  output ctrl_t            ctrl_q,
  output logic             fault,
  output logic [W-1:0]     tx_buf,
  output logic [REG_W-1:0] reg_rdata
);
  logic flag_q, armed_q;
  logic data_acc, stat_rd;

  assign data_acc = (reg_wr || reg_rd) && (reg_sel == SEL_DATA);
  assign stat_rd  = reg_rd && (reg_sel == SEL_STAT);
  // R12: another master pulls select low while it is an input
  assign fault    = ctrl_q.enable && ctrl_q.master && !ctrl_q.ss_is_out && !ss_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (reg_wr && reg_sel == SEL_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
      if (fault) ctrl_q.master <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tx_buf <= '0;
    else if (reg_wr && reg_sel == SEL_DATA) tx_buf <= reg_wdata[W-1:0];
  end

  // R5/R6: completion flag with read-status-then-access clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (done || fault)             flag_q <= 1'b1;
      else if (armed_q && data_acc)  flag_q <= 1'b0;
      if (data_acc)                  armed_q <= 1'b0;
      else if (stat_rd && flag_q)    armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_sel)
        SEL_CTRL: reg_rdata <= ctrl_q;
        SEL_STAT: reg_rdata <= {flag_q, {(REG_W-2){1'b0}}, busy};
        SEL_DATA: reg_rdata <= REG_W'(rx_byte);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  p_fault_drops_master_r12: assert property (@(posedge clk) disable iff (rst)
    fault |=> (!ctrl_q.master && flag_q))
    else $error("mode fault did not clear master or set flag");

  p_flag_clear_path_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(armed_q && data_acc))
    else $error("flag cleared without status read then data access");
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
  import spi_mf_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             ss_i,
  output logic             ss_o,
  output logic             ss_oe
);
  localparam int unsigned NPIN = 3;

  ctrl_t        ctrl;
  logic         fault, busy, done, out_bit;
  logic         sck_q, m_lead, m_trail;
  logic [W-1:0] tx_buf, rx_byte;
  logic [NPIN-1:0] pins_s;
  logic         ss_s, sck_s, mosi_s;
  logic         m_act, slv_sel, data_wr;

  spi_mf_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({ss_i, sck_i, mosi_i}), .q(pins_s)
  );
  assign ss_s   = pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  assign m_act   = ctrl.enable && ctrl.master;
  assign slv_sel = ctrl.enable && !ctrl.master && !ss_s;
  assign data_wr = reg_wr && (reg_sel == SEL_DATA);

  spi_mf_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .ss_s(ss_s), .busy(busy), .done(done), .rx_byte(rx_byte),
    .ctrl_q(ctrl), .fault(fault), .tx_buf(tx_buf), .reg_rdata(reg_rdata)
  );

  spi_mf_clkgen #(.SEL_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .run(busy && m_act), .halt(fault), .half_sel(ctrl.div_sel),
    .sck_q(sck_q), .lead(m_lead), .trail(m_trail)
  );

  spi_mf_engine #(.W(W)) u_engine (
    .clk(clk), .rst(rst), .is_master(m_act), .slv_sel(slv_sel), .abort(fault),
    .start(data_wr), .start_byte(reg_wdata[W-1:0]), .tx_buf(tx_buf),
    .m_lead(m_lead), .m_trail(m_trail), .sck_s(sck_s), .mosi_s(mosi_s), .miso_raw(miso_i),
    .busy(busy), .done(done), .out_bit(out_bit), .rx_byte(rx_byte)
  );

  // Registered pad direction control (R9, R11, R12, R13)
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_oe  <= 1'b0;
      mosi_oe <= 1'b0;
      miso_oe <= 1'b0;
      ss_oe   <= 1'b0;
      ss_o    <= 1'b0;
    end else begin
      sck_oe  <= m_act && !fault;
      mosi_oe <= m_act && !fault;
      ss_oe   <= m_act && ctrl.ss_is_out;
      ss_o    <= ctrl.ss_level;
      miso_oe <= slv_sel && ctrl.miso_drv;
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = out_bit;
  assign miso_o = out_bit;

  p_sck_low_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck_o)
    else $error("SCK high with no transfer running");

  p_oe_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> (!sck_oe && !mosi_oe))
    else $error("slave and master drivers enabled together");
endmodule

// File: tb/spi_mf_ctrl_tb_top.sv
`timescale 1ns/100ps
module spi_mf_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_sel = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_i = 1'b1, miso_i;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mdl_tx = '0, mdl_rx = '0;
  realtime    last_rise = 0.0, per_ns = 0.0;
  bit         have_rise = 1'b0;

  always #2.5 clk = ~clk;

  spi_mf_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  // external slave model for master-mode transfers
  assign miso_i = mdl_tx[7];
  always @(posedge sck_o) begin
    mdl_rx = {mdl_rx[6:0], mosi_o};
    if (have_rise) per_ns = $realtime - last_rise;
    last_rise = $realtime;
    have_rise = 1'b1;
  end
  always @(negedge sck_o) mdl_tx = {mdl_tx[6:0], 1'b0};

  // divider select, byte sent, byte returned by the model
  localparam logic [18:0] VEC [4] = '{
    {3'd0, 8'hA5, 8'h3C},
    {3'd1, 8'h0F, 8'hF0},
    {3'd2, 8'h81, 8'h7E},
    {3'd3, 8'h6D, 8'hB2}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    reg_sel = s; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  localparam int SHALF = 6;
  task automatic slave_xfer(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi_i = b[i];
      wait_clk(SHALF);
      got = {got[6:0], miso_o};
      sck_i = 1'b1;
      wait_clk(SHALF);
      sck_i = 1'b0;
    end
    wait_clk(SHALF);
  endtask

  task automatic run_master(input logic [2:0] dv, input logic [7:0] tx, input logic [7:0] rb);
    logic [7:0] s, v;
    wr(2'd0, {1'b0, dv, 1'b0, 1'b0, 1'b1, 1'b1});
    mdl_tx = rb;
    have_rise = 1'b0;
    wr(2'd2, tx);
    rd(2'd1, s);
    chk("R5", "busy during transfer", 32'(s[0]), 32'd1);
    for (int k = 0; k < 400 && s[0]; k++) rd(2'd1, s);
    chk("R5", "flag after byte", 32'(s[7]), 32'd1);
    rd(2'd2, v);
    chk("R3", "master received byte", 32'(v), 32'(rb));
    chk("R3", "byte seen on mosi", 32'(mdl_rx), 32'(tx));
    chk("R3", "sck idles low", 32'(sck_o), 32'd0);
    chk("R4", "sck period ns", 32'(int'(per_ns)), 32'(5 * (2 ** (int'(dv) + 1))));
    rd(2'd1, s);
    chk("R6", "flag cleared by status then data", 32'(s[7]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, s, got;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);

    // R1 reset state
    rd(2'd0, v); chk("R1", "ctrl after reset", 32'(v), 32'h00);
    rd(2'd1, v); chk("R1", "status after reset", 32'(v), 32'h00);
    chk("R1", "enables after reset", 32'({sck_oe, mosi_oe, miso_oe, ss_oe}), 32'h0);
    chk("R1", "sck after reset", 32'(sck_o), 32'd0);

    // R2 readback
    wr(2'd0, 8'h5B); rd(2'd0, v); chk("R2", "ctrl readback", 32'(v), 32'h5B);
    wr(2'd0, 8'h00); wait_clk(3);

    // R3/R4/R5/R6 master table
    for (int n = 0; n < 4; n++) run_master(VEC[n][18:16], VEC[n][15:8], VEC[n][7:0]);
    chk("R9", "miso_oe off as master", 32'(miso_oe), 32'd0);

    // R6 data access without status read keeps flag
    wr(2'd0, 8'h03);
    mdl_tx = 8'hC6;
    wr(2'd2, 8'h5E);
    wait_clk(40);
    rd(2'd2, v); chk("R3", "rx with div 0", 32'(v), 32'hC6);
    rd(2'd1, s); chk("R6", "flag kept without status read", 32'(s[7]), 32'd1);
    rd(2'd2, v);
    rd(2'd1, s); chk("R6", "flag cleared after sequence", 32'(s[7]), 32'd0);

    // R11 master with SS as output ignores ss_i
    wr(2'd0, 8'h87);
    ss_i = 1'b0; wait_clk(8);
    rd(2'd0, v); chk("R11", "master kept", 32'(v), 32'h87);
    rd(2'd1, s); chk("R11", "no flag", 32'(s[7]), 32'd0);
    chk("R11", "ss_oe and ss_o", 32'({ss_oe, ss_o, sck_oe}), 32'h7);
    ss_i = 1'b1; wait_clk(4);

    // R12 mode fault mid transfer
    wr(2'd0, 8'h53);
    mdl_tx = 8'h00;
    wr(2'd2, 8'hFF);
    wait_clk(70);
    ss_i = 1'b0; wait_clk(6);
    chk("R12", "sck/mosi enables dropped", 32'({sck_oe, mosi_oe}), 32'h0);
    chk("R12", "sck low after abort", 32'(sck_o), 32'd0);
    rd(2'd0, v); chk("R12", "master bit cleared", 32'(v), 32'h51);
    rd(2'd1, s); chk("R12", "flag set, not busy", 32'(s), 32'h80);
    ss_i = 1'b1; wait_clk(6);

    // R13 stays slave until master bit rewritten
    wr(2'd2, 8'h11); wait_clk(10);
    chk("R13", "no sck drive after fault", 32'({sck_oe, sck_o}), 32'h0);
    rd(2'd0, v); chk("R13", "master still clear", 32'(v[1]), 32'd0);
    wr(2'd0, 8'h53); wait_clk(3);
    chk("R13", "master restored", 32'({sck_oe, mosi_oe}), 32'h3);
    wr(2'd0, 8'h00); wait_clk(3);

    // R7/R9 slave byte
    wr(2'd0, 8'h09);
    wr(2'd2, 8'hC3);
    ss_i = 1'b0; wait_clk(5);
    chk("R9", "miso_oe selected", 32'(miso_oe), 32'd1);
    slave_xfer(8'h5A, 8, got);
    chk("R7", "slave sent byte", 32'(got), 32'hC3);
    rd(2'd1, s); chk("R5", "slave flag", 32'(s[7]), 32'd1);
    rd(2'd2, v); chk("R7", "slave received byte", 32'(v), 32'h5A);
    ss_i = 1'b1; wait_clk(5);
    chk("R9", "miso_oe deselected", 32'(miso_oe), 32'd0);

    // R8 deselected slave ignores activity
    wr(2'd2, 8'h77);
    slave_xfer(8'hFF, 8, got);
    rd(2'd1, s); chk("R8", "no flag when deselected", 32'(s[7]), 32'd0);
    rd(2'd2, v); chk("R8", "rx unchanged", 32'(v), 32'h5A);

    // R10 partial byte discarded on SS rise
    ss_i = 1'b0; wait_clk(4);
    slave_xfer(8'h0F, 3, got);
    ss_i = 1'b1; wait_clk(6);
    rd(2'd1, s); chk("R10", "partial gives no flag", 32'(s[7]), 32'd0);
    ss_i = 1'b0; wait_clk(4);
    slave_xfer(8'h96, 8, got);
    chk("R10", "tx restarted aligned", 32'(got), 32'h77);
    rd(2'd1, s);
    rd(2'd2, v); chk("R10", "rx aligned after resync", 32'(v), 32'h96);
    ss_i = 1'b1; wait_clk(4);

    // R9 drive bit clear keeps MISO released
    wr(2'd0, 8'h01);
    ss_i = 1'b0; wait_clk(5);
    chk("R9", "miso_oe without drive bit", 32'(miso_oe), 32'd0);
    ss_i = 1'b1; wait_clk(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule